// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Program Counter Unit

This block owns the program counter of a single-cycle processor whose instructions are 1, 2, 9 or 10 bytes long. In every cycle the surrounding fetch path presents the block with a window of instruction bytes that starts at the current PC. The block splits the first bytes into an operation code, a function code and two register specifiers. It also extracts the 8-byte constant from the byte offset that the operation uses. From the instruction length it forms the fall-through address, which is also the return address that a call saves.

At each clock edge the block loads the next PC. The next PC comes from one of four sources: the fall-through address, the extracted constant (the jump or call target), a value read from memory (the return address), or the current PC itself. The PC holds on a halt instruction and on an undefined operation code. The data memories, the register file, the ALU and the condition logic sit outside the block. The branch decision arrives on a single flag.

Top module: `ifetch_pc_unit`

## Requirements
- R1: After the asynchronous active-low reset the PC reads 0. Asserting reset in the middle of a run clears the PC at once.
- R2: Byte k of the window occupies bits 8k+7:8k. The operation code is bits 7:4 and the function code is bits 3:0. The first register specifier is bits 15:12 and the second is bits 11:8.
- R3: Operation codes 1 (no-op) advance the PC by 1. Codes 2 (conditional/register move), 6 (arithmetic), 10 (push) and 11 (pop) advance it by 2.
- R4: Codes 3, 4 and 5 (immediate, store and load moves) take the constant from window bytes 2 to 9, little-endian. They advance the PC by 10.
- R5: Codes 7 (jump) and 8 (call) take the constant from window bytes 1 to 8, little-endian. For these codes the fall-through output is PC+9.
- R6: For code 7 the next PC is the constant when the taken flag is 1 and PC+9 when it is 0.
- R7: For code 8 the next PC is the constant, whatever the taken flag.
- R8: For code 9 (return) the next PC is the memory read value.
- R9: Code 0 (halt) keeps the PC unchanged for as long as it is presented.
- R10: Codes 12 to 15 raise the invalid flag and keep the PC unchanged. Codes 0 to 11 leave the flag low.
- R11: The taken flag and the memory read value have no effect on the next PC for codes other than 7 (taken flag) and 9 (memory value).
- R12: Every PC addition wraps modulo 2^ADDR_W.
- R13: For operations that carry no constant, the constant output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| win_i | input | 8*(ADDR_W/8+2) | Instruction bytes starting at the PC, byte 0 in the low bits |
| taken_i | input | 1 | Branch condition result for jumps |
| mem_rdata_i | input | ADDR_W | Return address read from the stack |
| pc_o | output | ADDR_W | Current program counter |
| icode_o | output | 4 | Operation code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register specifier |
| rb_o | output | 4 | Second register specifier |
| const_o | output | ADDR_W | Extracted constant (zero when absent) |
| seq_pc_o | output | ADDR_W | Fall-through address, PC plus instruction length |
| invalid_o | output | 1 | Undefined operation code in byte 0 |

## Verification
The bench builds the block with its default ADDR_W of 64. That gives an 8-byte constant and a 10-byte window, so the 1, 2, 9 and 10 byte advances all appear exactly as specified. Because the PC is 64 bits wide, a taken jump to the top of the address space followed by short and long instructions brings the modulo wrap of both the fall-through adder and the loaded PC within reach. Each of the four next-PC sources is selected with the taken flag and the memory value driven to misleading values. This shows that only the correct operation consumes them.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  typedef enum logic [3:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_RRMOV = 4'h2,
    OP_IRMOV = 4'h3,
    OP_RMMOV = 4'h4,
    OP_MRMOV = 4'h5,
    OP_ALU   = 4'h6,
    OP_JMP   = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opcode_e;

  localparam logic [3:0] OP_LAST = 4'hB;

  typedef enum logic [1:0] {
    CPOS_NONE = 2'd0,
    CPOS_AT1  = 2'd1,
    CPOS_AT2  = 2'd2
  } cpos_e;

  typedef enum logic [1:0] {
    NSRC_SEQ  = 2'd0,
    NSRC_IMM  = 2'd1,
    NSRC_MEM  = 2'd2,
    NSRC_HOLD = 2'd3
  } nsrc_e;

  function automatic cpos_e const_pos(input logic [3:0] code);
    case (code)
      OP_IRMOV, OP_RMMOV, OP_MRMOV: const_pos = CPOS_AT2;
      OP_JMP, OP_CALL:              const_pos = CPOS_AT1;
      default:                      const_pos = CPOS_NONE;
    endcase
  endfunction

  function automatic logic has_regs(input logic [3:0] code);
    case (code)
      OP_RRMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV,
      OP_ALU, OP_PUSH, OP_POP: has_regs = 1'b1;
      default:                 has_regs = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ifetch_rst_sync.sv
module ifetch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ifetch_split.sv
module ifetch_split
  import ifetch_pkg::*;
#(
  parameter int ADDR_W = 64,
  localparam int CBYTES = ADDR_W / 8,
  localparam int WBYTES = CBYTES + 2,
  localparam int WIN_W  = WBYTES * 8,
  localparam int LEN_W  = $clog2(WBYTES + 1)
) (
  input  logic [WIN_W-1:0]  win_i,
  output logic [3:0]        icode_o,
  output logic [3:0]        ifun_o,
  output logic [3:0]        ra_o,
  output logic [3:0]        rb_o,
  output logic [ADDR_W-1:0] const_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              valid_o
);

  logic [7:0]        byte_q [WBYTES];
  logic [ADDR_W-1:0] imm_at1;
  logic [ADDR_W-1:0] imm_at2;
  logic [3:0]        code;
  cpos_e             pos;

  for (genvar gi = 0; gi < WBYTES; gi++) begin : g_bytes
    assign byte_q[gi] = win_i[gi*8 +: 8];
  end

  for (genvar gk = 0; gk < CBYTES; gk++) begin : g_imm
    assign imm_at1[gk*8 +: 8] = byte_q[gk+1];
    assign imm_at2[gk*8 +: 8] = byte_q[gk+2];
  end

  assign code    = byte_q[0][7:4];
  assign icode_o = code;
  assign ifun_o  = byte_q[0][3:0];
  assign ra_o    = byte_q[1][7:4];
  assign rb_o    = byte_q[1][3:0];
  assign valid_o = (code <= OP_LAST);
  assign pos     = const_pos(code);

  always_comb begin
    case (pos)
      CPOS_AT1: const_o = imm_at1;
      CPOS_AT2: const_o = imm_at2;
      default:  const_o = '0;
    endcase
  end

  always_comb begin
    if (pos == CPOS_AT2) begin
      len_o = LEN_W'(CBYTES + 2);
    end else if (pos == CPOS_AT1) begin
      len_o = LEN_W'(CBYTES + 1);
    end else if (has_regs(code)) begin
      len_o = LEN_W'(2);
    end else begin
      len_o = LEN_W'(1);
    end
  end

endmodule

// File: rtl/ifetch_next_sel.sv
module ifetch_next_sel
  import ifetch_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [3:0]        icode_i,
  input  logic              valid_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] mem_i,
  output logic [ADDR_W-1:0] seq_pc_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              load_o
);

  nsrc_e src;

  assign seq_pc_o = pc_i + ADDR_W'(len_i);

  always_comb begin
    if (!valid_i || icode_i == OP_HALT) begin
      src = NSRC_HOLD;
    end else begin
      case (icode_i)
        OP_CALL: src = NSRC_IMM;
        OP_JMP:  src = taken_i ? NSRC_IMM : NSRC_SEQ;
        OP_RET:  src = NSRC_MEM;
        default: src = NSRC_SEQ;
      endcase
    end
  end

  always_comb begin
    case (src)
      NSRC_IMM: next_pc_o = imm_i;
      NSRC_MEM: next_pc_o = mem_i;
      NSRC_SEQ: next_pc_o = seq_pc_o;
      default:  next_pc_o = pc_i;
    endcase
  end

  assign load_o = (src != NSRC_HOLD);

endmodule

// File: rtl/ifetch_pc_unit.sv
module ifetch_pc_unit
  import ifetch_pkg::*;
#(
  parameter int ADDR_W = 64,
  localparam int CBYTES = ADDR_W / 8,
  localparam int WIN_W  = (CBYTES + 2) * 8,
  localparam int LEN_W  = $clog2(CBYTES + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_W-1:0]  win_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [3:0]        icode_o,
  output logic [3:0]        ifun_o,
  output logic [3:0]        ra_o,
  output logic [3:0]        rb_o,
  output logic [ADDR_W-1:0] const_o,
  output logic [ADDR_W-1:0] seq_pc_o,
  output logic              invalid_o
);

  logic              rst_int_n;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic              pc_en;
  logic [LEN_W-1:0]  len;
  logic              valid;
  logic [3:0]        icode;
  logic [ADDR_W-1:0] imm;

  ifetch_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ifetch_split #(.ADDR_W(ADDR_W)) i_split (
    .win_i   (win_i),
    .icode_o (icode),
    .ifun_o  (ifun_o),
    .ra_o    (ra_o),
    .rb_o    (rb_o),
    .const_o (imm),
    .len_o   (len),
    .valid_o (valid)
  );

  ifetch_next_sel #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_next (
    .pc_i      (pc_q),
    .len_i     (len),
    .icode_i   (icode),
    .valid_i   (valid),
    .taken_i   (taken_i),
    .imm_i     (imm),
    .mem_i     (mem_rdata_i),
    .seq_pc_o  (seq_pc_o),
    .next_pc_o (pc_d),
    .load_o    (pc_en)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o      = pc_q;
  assign icode_o   = icode;
  assign const_o   = imm;
  assign invalid_o = !valid;

  // R1: PC stays at zero while the internal reset is held
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_int_n |=> (pc_q == '0 || rst_int_n));

  // R9: halt keeps the PC
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (icode == OP_HALT) |=> (pc_q == $past(pc_q)));

  // R10: undefined code keeps the PC
  p_bad_hold_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    invalid_o |=> (pc_q == $past(pc_q)));

  // R8: return loads the memory value
  p_ret_load_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (icode == OP_RET) |=> (pc_q == $past(mem_rdata_i)));

  // R7: call loads the constant
  p_call_load_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (icode == OP_CALL) |=> (pc_q == $past(const_o)));

  // R3: arithmetic op advances by two
  p_alu_step_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (icode == OP_ALU) |=> (pc_q == $past(pc_q) + ADDR_W'(2)));

endmodule

// File: tb/test_ifetch_pc_unit.sv
module test_ifetch_pc_unit;

  localparam int AW    = 64;
  localparam int WIN_W = (AW / 8 + 2) * 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [WIN_W-1:0] win;
  logic             taken;
  logic [AW-1:0]    mdata;
  logic [AW-1:0]    pc, cval, seq;
  logic [3:0]       icode, ifun, ra, rb;
  logic             invalid;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] exp_pc;
  bit done = 0;

  always #5 clk = ~clk;

  ifetch_pc_unit #(.ADDR_W(AW)) i_ifetch_pc_unit (
    .clk(clk), .rst_n(rst_n), .win_i(win), .taken_i(taken),
    .mem_rdata_i(mdata), .pc_o(pc), .icode_o(icode), .ifun_o(ifun),
    .ra_o(ra), .rb_o(rb), .const_o(cval), .seq_pc_o(seq),
    .invalid_o(invalid)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WIN_W-1:0] w_short(input logic [7:0] b0,
                                               input logic [7:0] b1);
    return {64'h5a5a_5a5a_5a5a_5a5a, b1, b0};
  endfunction

  function automatic logic [WIN_W-1:0] w_at2(input logic [7:0] b0,
                                             input logic [7:0] b1,
                                             input logic [63:0] k);
    return {k, b1, b0};
  endfunction

  function automatic logic [WIN_W-1:0] w_at1(input logic [7:0] b0,
                                             input logic [63:0] k);
    return {8'hc3, k, b0};
  endfunction

  // drive at negedge, check after the next rising edge
  task automatic step(input logic [WIN_W-1:0] w, input logic t,
                      input logic [AW-1:0] m);
    @(negedge clk);
    win = w; taken = t; mdata = m;
    #1;
  endtask

  task automatic edge_check(input string tag);
    @(posedge clk); #1;
    chk(tag, pc, exp_pc);
  endtask

  task automatic jump_to(input logic [AW-1:0] tgt);
    step(w_at1(8'h70, tgt), 1'b1, '0);
    exp_pc = tgt;
    edge_check("R6 jump setup");
  endtask

  task automatic t_reset;
    rst_n = 1'b0; win = '0; taken = 1'b0; mdata = '0;
    repeat (4) @(posedge clk);
    #1 chk("R1 pc in reset", pc, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 pc after release", pc, '0);
    exp_pc = '0;
  endtask

  task automatic t_fields;
    step(w_short(8'h64, 8'h3c), 1'b0, '0);
    chk("R2 icode", AW'(icode), AW'(4'h6));
    chk("R2 ifun", AW'(ifun), AW'(4'h4));
    chk("R2 ra", AW'(ra), AW'(4'h3));
    chk("R2 rb", AW'(rb), AW'(4'hc));
    chk("R13 const none", cval, '0);
    exp_pc = exp_pc + 2;
    edge_check("R3 alu advance");
  endtask

  task automatic t_short;
    step(w_short(8'h10, 8'hff), 1'b0, '0);
    chk("R3 nop seq", seq, exp_pc + 1);
    exp_pc = exp_pc + 1; edge_check("R3 nop advance");
    step(w_short(8'h21, 8'h12), 1'b0, '0);
    exp_pc = exp_pc + 2; edge_check("R3 move advance");
    step(w_short(8'ha0, 8'h4f), 1'b0, '0);
    exp_pc = exp_pc + 2; edge_check("R3 push advance");
    step(w_short(8'hb0, 8'h4f), 1'b0, '0);
    exp_pc = exp_pc + 2; edge_check("R3 pop advance");
  endtask

  task automatic t_long;
    for (int i = 3; i <= 5; i++) begin
      step(w_at2(8'(i << 4), 8'hf2, 64'h0807_0605_0403_0201 * i), 1'b0, '0);
      chk("R4 const at byte 2", cval, 64'h0807_0605_0403_0201 * i);
      exp_pc = exp_pc + 10;
      edge_check("R4 advance by 10");
    end
  endtask

  task automatic t_jump;
    step(w_at1(8'h73, 64'h1122_3344_5566_7788), 1'b0, 64'hdead);
    chk("R5 const at byte 1", cval, 64'h1122_3344_5566_7788);
    chk("R5 seq pc+9", seq, exp_pc + 9);
    exp_pc = exp_pc + 9;
    edge_check("R6 not taken");
    step(w_at1(8'h70, 64'h0000_0000_0000_4000), 1'b1, 64'hdead);
    exp_pc = 64'h4000;
    edge_check("R6 taken");
  endtask

  task automatic t_call_ret;
    step(w_at1(8'h80, 64'h0000_0000_0000_8000), 1'b0, 64'hbeef);
    chk("R5 call return addr", seq, exp_pc + 9);
    exp_pc = 64'h8000;
    edge_check("R7 call taken=0");
    step(w_at1(8'h80, 64'h0000_0000_0000_9000), 1'b1, 64'hbeef);
    exp_pc = 64'h9000;
    edge_check("R7 call taken=1");
    step(w_short(8'h90, 8'h00), 1'b1, 64'h0000_0000_0000_4009);
    exp_pc = 64'h4009;
    edge_check("R8 return");
  endtask

  task automatic t_halt;
    for (int i = 0; i < 3; i++) begin
      step(w_short(8'h00, 8'h11), 1'b1, 64'h7777);
      chk("R10 halt not invalid", AW'(invalid), '0);
      edge_check("R9 halt hold");
    end
  endtask

  task automatic t_invalid;
    for (int c = 12; c <= 15; c++) begin
      step(w_at1(8'(c << 4), 64'h2222), 1'b1, 64'h3333);
      chk("R10 flag raised", AW'(invalid), 64'd1);
      edge_check("R10 pc hold");
    end
    step(w_short(8'hb0, 8'h00), 1'b0, '0);
    chk("R10 flag low for 11", AW'(invalid), '0);
    exp_pc = exp_pc + 2; edge_check("R10 after invalid");
  endtask

  task automatic t_ignored;
    step(w_short(8'h60, 8'h01), 1'b1, 64'h0bad_0bad);
    exp_pc = exp_pc + 2; edge_check("R11 alu ignores inputs");
    step(w_at2(8'h30, 8'hf1, 64'h1234), 1'b1, 64'h0bad_0bad);
    exp_pc = exp_pc + 10; edge_check("R11 irmov ignores inputs");
    step(w_at1(8'h75, 64'h5555), 1'b0, 64'h0bad_0bad);
    exp_pc = exp_pc + 9; edge_check("R11 jump ignores memory");
  endtask

  task automatic t_wrap;
    jump_to(64'hffff_ffff_ffff_ffff);
    step(w_short(8'h10, 8'h00), 1'b0, '0);
    exp_pc = '0; edge_check("R12 nop wrap");
    jump_to(64'hffff_ffff_ffff_fff8);
    step(w_at2(8'h40, 8'h12, 64'h9), 1'b0, '0);
    exp_pc = 64'h2; edge_check("R12 long wrap");
  endtask

  task automatic t_midreset;
    @(negedge clk);
    rst_n = 1'b0; win = '0;
    #1 chk("R1 async clear", pc, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1 held after release", pc, '0);
    exp_pc = '0;
  endtask

  initial begin
    t_reset();
    t_fields();
    t_short();
    t_long();
    t_jump();
    t_call_ret();
    t_halt();
    t_invalid();
    t_ignored();
    t_wrap();
    t_midreset();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule